// File: doc/BRIEF.md
# Registered 12-to-24-bit Bus Exchanger

This block links one narrow data port, A, to a pair of ports of the same width, called B1 and B2. Traffic from A to the B side goes through two capture registers. Each has its own active-low load enable. Loading B1 on one cycle and B2 on the next turns two words that arrive one after another on A into a single double-width word across B1 and B2.

Traffic from the B side to A goes through a single register. That register reloads on every rising clock edge, taking B1 when the select input is high and B2 when it is low. Every control is sampled on the rising clock edge, including the three active-low output enables. So a change on any control takes effect only after the next edge.

Each bidirectional pin is split into an input, an output value and a drive-enable output. A port that must not drive shows this by holding its drive-enable low. The data ports carry no handshake and exert no back-pressure: the block accepts a value on every cycle and presents its register contents continuously.

Top module: `bus_exchanger`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the B1, B2 and A registers to zero and deasserts all three drive-enable outputs on the following cycle.
- R2: The B1 register takes `a_in` at a rising edge when `load1_n` is 0 and keeps its value when `load1_n` is 1.
- R3: The B2 register takes `a_in` at a rising edge when `load2_n` is 0 and keeps its value when `load2_n` is 1.
- R4: The A register reloads on every rising edge, from `b1_in` when `pick_b1` is 1 and from `b2_in` when `pick_b1` is 0.
- R5: Each drive-enable output equals the inverse of its active-low enable input as sampled at the previous rising edge, so it responds one cycle after the input changes.
- R6: The three enables are independent: B1 and B2 may drive together, and the A enable does not depend on either B enable.
- R7: With `load1_n` 0 on one edge, then `load2_n` 0 and `load1_n` 1 on the next edge, the two consecutive A words appear together as {`b2_out`, `b1_out`}.
- R8: `a_out`, `b1_out` and `b2_out` always show their register contents, whether or not the matching drive-enable is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load1_n | input | 1 | Active-low load enable of the B1 register |
| load2_n | input | 1 | Active-low load enable of the B2 register |
| pick_b1 | input | 1 | 1 selects B1, 0 selects B2 as the source of the A register |
| a_oe_n | input | 1 | Active-low output enable of port A (registered) |
| b1_oe_n | input | 1 | Active-low output enable of port B1 (registered) |
| b2_oe_n | input | 1 | Active-low output enable of port B2 (registered) |
| a_in | input | DW | Value seen on the A pins |
| a_out | output | DW | Value A would drive |
| a_drive | output | 1 | A pins driven when 1 |
| b1_in | input | DW | Value seen on the B1 pins |
| b1_out | output | DW | Value B1 would drive |
| b1_drive | output | 1 | B1 pins driven when 1 |
| b2_in | input | DW | Value seen on the B2 pins |
| b2_out | output | DW | Value B2 would drive |
| b2_drive | output | 1 | B2 pins driven when 1 |

## Verification
Word assembly is tried with different values on A in the two load cycles, so that a swap of halves or a register loaded from the wrong cycle shows up. Hold is tried with both load enables high while A keeps changing, which catches any leak from A into the B registers. The A path is driven with distinct B1 and B2 values while the select alternates, which separates the two sources and shows any inverted select. Enables are toggled one at a time and in combinations, and each is checked in the cycle before and the cycle after its edge to confirm the one-cycle delay and their independence.

// File: rtl/bx_pkg.sv
package bx_pkg;
  localparam int unsigned BX_DW    = 12;
  localparam int unsigned BX_NPORT = 3;
  localparam int unsigned BX_NCAP  = 2;

  typedef enum logic [1:0] {
    PORT_A  = 2'd0,
    PORT_B1 = 2'd1,
    PORT_B2 = 2'd2
  } port_e;
endpackage

// File: rtl/bx_capture.sv
module bx_capture #(
  parameter int unsigned DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_n,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  logic [DW-1:0] q_r;

  always_ff @(posedge clk) begin
    if (rst)          q_r <= '0;
    else if (!load_n) q_r <= d;
  end

  assign q = q_r;

  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    load_n |=> $stable(q)); // R2, R3
  AST_CAP_LOAD: assert property (@(posedge clk) disable iff (rst)
    !load_n |=> (q == $past(d))); // R2, R3
endmodule

// File: rtl/bx_return.sv
module bx_return #(
  parameter int unsigned DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pick_b1,
  input  logic [DW-1:0] b1,
  input  logic [DW-1:0] b2,
  output logic [DW-1:0] q
);
  logic [DW-1:0] src;
  logic [DW-1:0] q_r;

  always_comb begin
    if (pick_b1) src = b1;
    else         src = b2;
  end

  always_ff @(posedge clk) begin
    if (rst) q_r <= '0;
    else     q_r <= src;
  end

  assign q = q_r;

  AST_RET_B1: assert property (@(posedge clk) disable iff (rst)
    pick_b1 |=> (q == $past(b1))); // R4
  AST_RET_B2: assert property (@(posedge clk) disable iff (rst)
    !pick_b1 |=> (q == $past(b2))); // R4
endmodule

// File: rtl/bx_oe_sync.sv
module bx_oe_sync #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] oe_n,
  output logic [N-1:0] drive
);
  for (genvar i = 0; i < N; i++) begin : g_oe
    logic oe_q;
    always_ff @(posedge clk) begin
      if (rst) oe_q <= 1'b1;
      else     oe_q <= oe_n[i];
    end
    assign drive[i] = ~oe_q;

    AST_OE_DELAY: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (drive[i] == !$past(oe_n[i]))); // R5
    AST_OE_RESET: assert property (@(posedge clk)
      rst |=> !drive[i]); // R1
  end
endmodule

// File: rtl/bus_exchanger.sv
module bus_exchanger
  import bx_pkg::*;
#(
  parameter int unsigned DW = BX_DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load1_n,
  input  logic          load2_n,
  input  logic          pick_b1,
  input  logic          a_oe_n,
  input  logic          b1_oe_n,
  input  logic          b2_oe_n,
  input  logic [DW-1:0] a_in,
  output logic [DW-1:0] a_out,
  output logic          a_drive,
  input  logic [DW-1:0] b1_in,
  output logic [DW-1:0] b1_out,
  output logic          b1_drive,
  input  logic [DW-1:0] b2_in,
  output logic [DW-1:0] b2_out,
  output logic          b2_drive
);
  localparam int unsigned NCAP = BX_NCAP;
  localparam int unsigned NOE  = BX_NPORT;

  logic [NCAP-1:0] cap_ld_n;
  logic [DW-1:0]   cap_q [NCAP];
  logic [NOE-1:0]  oe_n_vec;
  logic [NOE-1:0]  drv_vec;

  assign cap_ld_n = {load2_n, load1_n};

  for (genvar g = 0; g < NCAP; g++) begin : g_cap
    bx_capture #(.DW(DW)) u_cap (
      .clk    (clk),
      .rst    (rst),
      .load_n (cap_ld_n[g]),
      .d      (a_in),
      .q      (cap_q[g])
    );
  end

  bx_return #(.DW(DW)) u_ret (
    .clk     (clk),
    .rst     (rst),
    .pick_b1 (pick_b1),
    .b1      (b1_in),
    .b2      (b2_in),
    .q       (a_out)
  );

  always_comb begin
    oe_n_vec = '1;
    oe_n_vec[int'(PORT_A)]  = a_oe_n;
    oe_n_vec[int'(PORT_B1)] = b1_oe_n;
    oe_n_vec[int'(PORT_B2)] = b2_oe_n;
  end

  bx_oe_sync #(.N(NOE)) u_oe (
    .clk   (clk),
    .rst   (rst),
    .oe_n  (oe_n_vec),
    .drive (drv_vec)
  );

  assign b1_out   = cap_q[0];
  assign b2_out   = cap_q[1];
  assign a_drive  = drv_vec[int'(PORT_A)];
  assign b1_drive = drv_vec[int'(PORT_B1)];
  assign b2_drive = drv_vec[int'(PORT_B2)];

  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> (a_out == '0 && b1_out == '0 && b2_out == '0)); // R1
  AST_WORD_PAIR: assert property (@(posedge clk) disable iff (rst)
    (!load2_n && load1_n && !$past(load1_n) && !$past(rst))
    |=> (b1_out == $past(a_in, 2) && b2_out == $past(a_in))); // R7
  AST_B_INDEP: assert property (@(posedge clk) disable iff (rst)
    (!b1_oe_n && !b2_oe_n) |=> (b1_drive && b2_drive)); // R6
endmodule

// File: tb/bus_exchanger_tb.sv
module bus_exchanger_tb;
  localparam int DW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load1_n = 1'b1, load2_n = 1'b1, pick_b1 = 1'b0;
  logic a_oe_n = 1'b1, b1_oe_n = 1'b1, b2_oe_n = 1'b1;
  logic [DW-1:0] a_in = '0, b1_in = '0, b2_in = '0;
  logic [DW-1:0] a_out, b1_out, b2_out;
  logic a_drive, b1_drive, b2_drive;

  always #2.5 clk = ~clk;

  bus_exchanger #(.DW(DW)) u_dut (
    .clk(clk), .rst(rst), .load1_n(load1_n), .load2_n(load2_n),
    .pick_b1(pick_b1), .a_oe_n(a_oe_n), .b1_oe_n(b1_oe_n), .b2_oe_n(b2_oe_n),
    .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
    .b1_in(b1_in), .b1_out(b1_out), .b1_drive(b1_drive),
    .b2_in(b2_in), .b2_out(b2_out), .b2_drive(b2_drive)
  );

  typedef struct {
    logic [DW-1:0] a, b1, b2;
    logic [2:0]    drv;   // {b2, b1, a}
    string         tag;
  } exp_t;

  exp_t sb[$];
  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference model state
  logic [DW-1:0] m_a = '0, m_b1 = '0, m_b2 = '0;
  logic [2:0]    m_oe = 3'b111;

  task automatic chk(string req, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s (%s) actual=%h expected=%h", req, tag, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the expected result
  task automatic step(input logic r, input logic l1, input logic l2, input logic pk,
                      input logic oa, input logic o1, input logic o2,
                      input logic [DW-1:0] a, input logic [DW-1:0] b1,
                      input logic [DW-1:0] b2, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; load1_n = l1; load2_n = l2; pick_b1 = pk;
    a_oe_n = oa; b1_oe_n = o1; b2_oe_n = o2;
    a_in = a; b1_in = b1; b2_in = b2;
    if (r) begin
      m_a = '0; m_b1 = '0; m_b2 = '0; m_oe = 3'b111;
    end else begin
      if (!l1) m_b1 = a;
      if (!l2) m_b2 = a;
      m_a = pk ? b1 : b2;
      m_oe = {o2, o1, oa};
    end
    e.a = m_a; e.b1 = m_b1; e.b2 = m_b2; e.drv = ~m_oe; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compares after each rising edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk("R4", e.tag, a_out, e.a);
      chk("R2", e.tag, b1_out, e.b1);
      chk("R3", e.tag, b2_out, e.b2);
      chk("R5", e.tag, {{(DW-3){1'b0}}, b2_drive, b1_drive, a_drive},
          {{(DW-3){1'b0}}, e.drv});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state, inputs busy during reset
    step(1, 0, 0, 1, 0, 0, 0, 12'hFFF, 12'hAAA, 12'h555, "R1 reset");
    step(1, 0, 0, 0, 0, 0, 0, 12'h0F0, 12'h111, 12'h222, "R1 reset");
    step(0, 1, 1, 0, 1, 1, 1, 12'h000, 12'h000, 12'h000, "R1 idle");
    // R7 word assembly: 123 into B1 then 456 into B2
    step(0, 0, 1, 0, 1, 1, 1, 12'h123, 12'h000, 12'h000, "R7 first half");
    step(0, 1, 0, 0, 1, 1, 1, 12'h456, 12'h000, 12'h000, "R7 second half");
    // R2 R3 hold with both loads high while A keeps moving
    step(0, 1, 1, 0, 1, 1, 1, 12'hBAD, 12'h000, 12'h000, "R2 R3 hold");
    step(0, 1, 1, 0, 1, 1, 1, 12'hFED, 12'h000, 12'h000, "R2 R3 hold");
    // R4 alternating select, distinct sources
    for (int i = 0; i < 6; i++)
      step(0, 1, 1, i[0], 1, 1, 1, 12'h000, 12'h300 + 12'(i), 12'hC00 + 12'(i), "R4 alternate");
    // R5 enables one at a time, R6 combinations
    step(0, 1, 1, 0, 0, 1, 1, 12'h000, 12'h000, 12'h000, "R5 a on");
    step(0, 1, 1, 0, 1, 0, 1, 12'h000, 12'h000, 12'h000, "R5 b1 on");
    step(0, 1, 1, 0, 1, 1, 0, 12'h000, 12'h000, 12'h000, "R5 b2 on");
    step(0, 1, 1, 0, 1, 0, 0, 12'h000, 12'h000, 12'h000, "R6 b1 b2 together");
    step(0, 1, 1, 0, 0, 0, 0, 12'h000, 12'h000, 12'h000, "R6 all on");
    step(0, 1, 1, 0, 0, 1, 1, 12'h000, 12'h000, 12'h000, "R6 a alone");
    // R8 values present while drives off
    step(0, 0, 0, 1, 1, 1, 1, 12'h7E7, 12'h9A9, 12'h000, "R8 load while off");
    step(0, 1, 1, 1, 1, 1, 1, 12'h000, 12'h000, 12'h000, "R8 held while off");
    // R7 again with swapped order of values
    step(0, 0, 1, 0, 0, 0, 0, 12'hE01, 12'h000, 12'h000, "R7 first half");
    step(0, 1, 0, 0, 0, 0, 0, 12'h10E, 12'h000, 12'h000, "R7 second half");
    // mixed pseudo-random traffic
    for (int i = 0; i < 40; i++)
      step(0, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 12'($urandom), 12'($urandom), 12'($urandom), "R2 R3 R4 R5 mix");
    // R1 reset in mid-run
    step(1, 0, 0, 1, 0, 0, 0, 12'h321, 12'h654, 12'h987, "R1 mid reset");
    step(0, 1, 1, 1, 1, 1, 1, 12'h000, 12'h000, 12'h000, "R1 after reset");
    @(negedge clk);
    repeat (3) @(posedge clk);
    #2;
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule